// File: doc/BRIEF.md
# Vertical Split-Screen Fetch Controller

This block sits between a tile renderer's background fetch stage and its memories. The renderer reports a tile column counter (0 to 33 across each scanline) and the draw phase. A split can be programmed on one side of a boundary column. Inside the split, the block redirects nametable and attribute lookups into a 1 KB on-chip RAM. It also redirects pattern lookups into a dedicated 4 KB pattern bank. The split region has its own vertical scroll, so it can show a region that scrolls independently from the main playfield.

Software programs the block through a plain register write port. The renderer pulses a horizontal-blank strobe with the current scanline number. The block latches that number and uses it for the whole next line. Each fetch is presented as a valid/ready request carrying its kind and offset. One cycle after acceptance, the block returns a result beat. The beat holds the substituted RAM address, the substituted pattern address and an override flag. When the override flag is low, the renderer performs its normal fetch.

Top module: `split_fetch_ctrl`

## Requirements
- R1: After reset, `out_valid` and `out_override` are 0, the split is disabled, and pattern substitution is disarmed.
- R2: A write with `wr_sel`=0 sets the split fields from `wr_data`: bit 7 enables the split, bit 6 selects the right side, and bits [4:0] give the boundary column. With the left side selected, a fetch is in the split when its tile < boundary.
- R3: With the right side selected, a fetch is in the split when its tile >= boundary.
- R4: A fetch with tile >= 34 is never in the split, whatever the side and the boundary.
- R5: Writing `wr_sel`=6 with bit 1 of `wr_data` set suppresses the split entirely. Other bits of that write have no effect.
- R6: Row = (vertical scroll, `wr_sel`=1) + latched scanline, modulo 256. A nametable fetch (`req_pat`=0, offset[9:0] < 0x3C0) in the split overrides with RAM address ((row & 0xF8) << 2) | (tile & 0x1F).
- R7: An attribute fetch (`req_pat`=0, offset[9:0] >= 0x3C0) in the split overrides with RAM address 0x3C0 | (((row & ~0x1F) | (tile & 0x1F)) >> 2).
- R8: A pattern fetch (`req_pat`=1) overrides only in the background phase (`phase_bg`=1), only in the split, and only while armed. Its address is bank × 4096 + (offset & 0x3F8) + (vertical scroll & 7), where bank is written with `wr_sel`=2.
- R9: A write with `wr_sel`=2 arms pattern substitution. Writes with `wr_sel`=3 (page-size mode), 4 (any pattern bank) or 5 (upper bank bits) disarm it. A write with `wr_sel`=7 changes nothing.
- R10: `scanline` is captured only when `hblank` is high. The captured value is used until the next capture.
- R11: `req_ready` = !`out_valid` | `out_ready`. An accepted request yields `out_valid` on the next cycle. While `out_valid` is 1 and `out_ready` is 0, every output field holds steady.
- R12: With the enable bit clear, no fetch is overridden.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select (codes in R2, R5, R6, R8, R9) |
| wr_data | input | 8 | Register write data |
| hblank | input | 1 | Horizontal-blank event; captures `scanline` |
| scanline | input | 8 | Current scanline number |
| tile_idx | input | 6 | Background tile column counter, 0..33 |
| phase_bg | input | 1 | 1 = background draw phase, 0 = sprite phase |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Fetch request accepted when high with `req_valid` |
| req_pat | input | 1 | 1 = pattern fetch, 0 = nametable/attribute fetch |
| req_off | input | 12 | Fetch offset within the page |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Consumer accepts the result beat |
| out_override | output | 1 | The fetch is replaced by the split source |
| out_ram_addr | output | 10 | Substituted on-chip RAM address |
| out_pat_addr | output | 20 | Substituted pattern memory address |

## Verification
On every cycle, the assertions check the result handshake: an accepted request yields a beat, and a stalled beat keeps its payload. They also check that nothing overrides past column 33, under suppression, or on a pattern fetch in the sprite phase, and that an overridden attribute fetch lands in the attribute area of RAM. Only the bench scenarios can show the exact boundary on each side and the substituted address values. The same holds for the arming and disarming order across register writes and for the scanline being held between horizontal-blank events.

// File: rtl/split_fetch_pkg.sv
package split_fetch_pkg;
  localparam int DATA_W     = 8;
  localparam int SEL_W      = 3;
  localparam int TILE_W     = 6;
  localparam int BOUND_W    = 5;
  localparam int TILE_LIMIT = 34;
  localparam int OFF_W      = 12;
  localparam int RAM_AW     = 10;
  localparam int BANK_W     = 8;
  localparam int PAT_AW     = BANK_W + 12;

  typedef enum logic [SEL_W-1:0] {
    SEL_CTRL    = 3'd0,
    SEL_VSCROLL = 3'd1,
    SEL_BANK    = 3'd2,
    SEL_PMODE   = 3'd3,
    SEL_PBANK   = 3'd4,
    SEL_UPPER   = 3'd5,
    SEL_EXMODE  = 3'd6,
    SEL_NONE    = 3'd7
  } wr_sel_e;

  typedef struct packed {
    logic              override;
    logic [RAM_AW-1:0] ram_addr;
    logic [PAT_AW-1:0] pat_addr;
  } fetch_result_t;
endpackage

// File: rtl/split_regs.sv
module split_regs
  import split_fetch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               hblank,
  input  logic [DATA_W-1:0]  scanline,
  output logic               enable_q,
  output logic               right_q,
  output logic [BOUND_W-1:0] bound_q,
  output logic [DATA_W-1:0]  vscroll_q,
  output logic [BANK_W-1:0]  bank_q,
  output logic               armed_q,
  output logic               suppress_q,
  output logic [DATA_W-1:0]  line_q
);
  wr_sel_e sel;
  assign sel = wr_sel_e'(wr_sel);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q   <= 1'b0;
      right_q    <= 1'b0;
      bound_q    <= '0;
      vscroll_q  <= '0;
      bank_q     <= '0;
      armed_q    <= 1'b0;
      suppress_q <= 1'b0;
    end else if (wr_en) begin
      unique case (sel)
        SEL_CTRL: begin
          enable_q <= wr_data[7];
          right_q  <= wr_data[6];
          bound_q  <= wr_data[BOUND_W-1:0];
        end
        SEL_VSCROLL: vscroll_q <= wr_data;
        SEL_BANK: begin
          bank_q  <= wr_data[BANK_W-1:0];
          armed_q <= 1'b1;
        end
        SEL_PMODE, SEL_PBANK, SEL_UPPER: armed_q <= 1'b0;
        SEL_EXMODE: suppress_q <= wr_data[1];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      line_q <= '0;
    else if (hblank) line_q <= scanline;
  end
endmodule

// File: rtl/split_window.sv
module split_window
  import split_fetch_pkg::*;
(
  input  logic [TILE_W-1:0]  tile,
  input  logic               enable,
  input  logic               right,
  input  logic [BOUND_W-1:0] bound,
  input  logic               suppress,
  output logic               in_split
);
  localparam logic [TILE_W-1:0] LIMIT = TILE_W'(TILE_LIMIT);

  logic [TILE_W-1:0] bound_ext;
  logic              side_hit;
  logic              tile_live;

  assign bound_ext = TILE_W'(bound);
  assign tile_live = tile < LIMIT;

  always_comb begin
    if (right) side_hit = tile >= bound_ext;
    else       side_hit = tile <  bound_ext;
  end

  assign in_split = enable && !suppress && tile_live && side_hit;
endmodule

// File: rtl/split_addr.sv
module split_addr
  import split_fetch_pkg::*;
(
  input  logic [DATA_W-1:0] vscroll,
  input  logic [DATA_W-1:0] line,
  input  logic [TILE_W-1:0] tile,
  input  logic [OFF_W-1:0]  off,
  input  logic [BANK_W-1:0] bank,
  output logic              is_attr,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [PAT_AW-1:0] pat_addr
);
  localparam logic [RAM_AW-1:0] ATTR_BASE = RAM_AW'(10'h3C0);

  logic [DATA_W-1:0] row;
  logic [RAM_AW-1:0] nt_addr;
  logic [RAM_AW-1:0] at_addr;

  assign row     = vscroll + line;
  assign is_attr = off[RAM_AW-1:0] >= ATTR_BASE;

  // Coarse row times 32 plus column.
  assign nt_addr = {row[7:3], tile[4:0]};
  // Attribute cell: 8x8 grid of 4x4-tile groups after the 960-byte table.
  assign at_addr = ATTR_BASE | RAM_AW'({row[7:5], tile[4:2]});
  assign ram_addr = is_attr ? at_addr : nt_addr;

  // Bank selects the 4 KB page; row of 8 bytes from the offset; fine line from scroll.
  assign pat_addr = {bank, 2'b00, off[9:3], vscroll[2:0]};
endmodule

// File: rtl/split_fetch_ctrl.sv
module split_fetch_ctrl
  import split_fetch_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [SEL_W-1:0]   wr_sel,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               hblank,
  input  logic [DATA_W-1:0]  scanline,
  input  logic [TILE_W-1:0]  tile_idx,
  input  logic               phase_bg,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_pat,
  input  logic [OFF_W-1:0]   req_off,
  output logic               out_valid,
  input  logic               out_ready,
  output logic               out_override,
  output logic [RAM_AW-1:0]  out_ram_addr,
  output logic [PAT_AW-1:0]  out_pat_addr
);
  logic               enable_q, right_q, armed_q, suppress_q;
  logic [BOUND_W-1:0] bound_q;
  logic [DATA_W-1:0]  vscroll_q, line_q;
  logic [BANK_W-1:0]  bank_q;
  logic               in_split, is_attr;
  logic [RAM_AW-1:0]  ram_addr;
  logic [PAT_AW-1:0]  pat_addr;
  logic               accept;
  fetch_result_t      next_res, res_q;

  split_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .hblank(hblank), .scanline(scanline),
    .enable_q(enable_q), .right_q(right_q), .bound_q(bound_q),
    .vscroll_q(vscroll_q), .bank_q(bank_q), .armed_q(armed_q),
    .suppress_q(suppress_q), .line_q(line_q)
  );

  split_window u_window (
    .tile(tile_idx), .enable(enable_q), .right(right_q), .bound(bound_q),
    .suppress(suppress_q), .in_split(in_split)
  );

  split_addr u_addr (
    .vscroll(vscroll_q), .line(line_q), .tile(tile_idx), .off(req_off),
    .bank(bank_q), .is_attr(is_attr), .ram_addr(ram_addr), .pat_addr(pat_addr)
  );

  always_comb begin
    next_res.ram_addr = ram_addr;
    next_res.pat_addr = pat_addr;
    if (req_pat) next_res.override = in_split && phase_bg && armed_q;
    else         next_res.override = in_split;
  end

  assign req_ready = !out_valid || out_ready;
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      res_q     <= next_res;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_override = out_valid && res_q.override;
  assign out_ram_addr = res_q.ram_addr;
  assign out_pat_addr = res_q.pat_addr;
endmodule

// File: rtl/split_fetch_chk.sv
module split_fetch_chk
  import split_fetch_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_pat,
  input logic [OFF_W-1:0]  req_off,
  input logic [TILE_W-1:0] tile_idx,
  input logic              phase_bg,
  input logic              suppress,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_override,
  input logic [RAM_AW-1:0] out_ram_addr,
  input logic [PAT_AW-1:0] out_pat_addr
);
  logic acc;
  assign acc = req_valid && req_ready;

  assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!out_valid && !out_override));

  assert_beat_follows_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_override)
      && $stable(out_ram_addr) && $stable(out_pat_addr)));

  assert_no_split_past_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && tile_idx >= TILE_W'(TILE_LIMIT)) |=> !out_override);

  assert_suppress_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && suppress) |=> !out_override);

  assert_attr_region_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_pat && req_off[9:0] >= 10'h3C0) |=>
      (!out_override || out_ram_addr[9:6] == 4'hF));

  assert_pattern_bg_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_pat && !phase_bg) |=> !out_override);
endmodule

bind split_fetch_ctrl split_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_pat(req_pat), .req_off(req_off), .tile_idx(tile_idx), .phase_bg(phase_bg),
  .suppress(suppress_q), .out_valid(out_valid), .out_ready(out_ready),
  .out_override(out_override), .out_ram_addr(out_ram_addr), .out_pat_addr(out_pat_addr)
);

// File: tb/split_fetch_ctrl_tb.sv
module split_fetch_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_sel = '0;
  logic [7:0]  wr_data = '0;
  logic        hblank = 1'b0;
  logic [7:0]  scanline = '0;
  logic [5:0]  tile_idx = '0;
  logic        phase_bg = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_pat = 1'b0;
  logic [11:0] req_off = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_override;
  logic [9:0]  out_ram_addr;
  logic [19:0] out_pat_addr;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  logic [7:0] vs_m = 8'h1D;
  logic [7:0] line_m = 8'h0A;
  logic [7:0] bank_m = 8'h3A;

  always #10 clk = ~clk;

  split_fetch_ctrl u_dut (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected < 20000)", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic hb(input logic [7:0] line);
    @(negedge clk); hblank = 1'b1; scanline = line;
    @(negedge clk); hblank = 1'b0;
  endtask

  // Issues one fetch and samples the result beat one edge later.
  task automatic fetch(input logic pat, input logic [11:0] off, input logic [5:0] tile, input logic bg);
    @(negedge clk);
    req_valid = 1'b1; req_pat = pat; req_off = off; tile_idx = tile; phase_bg = bg;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  function automatic logic [9:0] exp_nt(input logic [7:0] r, input logic [5:0] t);
    return 10'(((r & 8'hF8) * 4) + (t & 6'h1F));
  endfunction
  function automatic logic [9:0] exp_at(input logic [7:0] r, input logic [5:0] t);
    return 10'h3C0 | 10'(((r & 8'hE0) | (t & 6'h1F)) / 4);
  endfunction
  function automatic logic [19:0] exp_pat(input logic [7:0] b, input logic [11:0] o, input logic [7:0] v);
    return 20'(b) * 20'd4096 + 20'(o & 12'h3F8) + 20'(v & 8'h07);
  endfunction

  task automatic t_reset;
    check("R1 out_valid after reset", 32'(out_valid), 0);
    check("R1 override after reset", 32'(out_override), 0);
    fetch(1'b0, 12'h010, 6'd0, 1'b1);
    check("R1 split disabled after reset", 32'(out_override), 0);
  endtask

  task automatic t_left;
    wr(3'd1, vs_m);
    hb(line_m);
    wr(3'd0, 8'h85);
    fetch(1'b0, 12'h020, 6'd4, 1'b1);
    check("R2 left tile 4 < 5 overrides", 32'(out_override), 1);
    check("R6 nametable address", 32'(out_ram_addr), 32'(exp_nt(vs_m + line_m, 6'd4)));
    fetch(1'b0, 12'h020, 6'd5, 1'b1);
    check("R2 left tile 5 not in split", 32'(out_override), 0);
  endtask

  task automatic t_right;
    wr(3'd0, 8'hC5);
    fetch(1'b0, 12'h020, 6'd4, 1'b1);
    check("R3 right tile 4 not in split", 32'(out_override), 0);
    fetch(1'b0, 12'h020, 6'd5, 1'b1);
    check("R3 right tile 5 in split", 32'(out_override), 1);
    fetch(1'b0, 12'h020, 6'd33, 1'b1);
    check("R3 right tile 33 in split", 32'(out_override), 1);
    check("R6 nametable tile 33", 32'(out_ram_addr), 32'(exp_nt(vs_m + line_m, 6'd33)));
    fetch(1'b0, 12'h020, 6'd34, 1'b1);
    check("R4 tile 34 never in split", 32'(out_override), 0);
    wr(3'd0, 8'hC0);
    fetch(1'b0, 12'h020, 6'd35, 1'b1);
    check("R4 tile 35 boundary 0", 32'(out_override), 0);
  endtask

  task automatic t_attr;
    wr(3'd0, 8'h9F);
    fetch(1'b0, 12'h3C5, 6'd13, 1'b1);
    check("R7 attribute override", 32'(out_override), 1);
    check("R7 attribute address", 32'(out_ram_addr), 32'(exp_at(vs_m + line_m, 6'd13)));
  endtask

  task automatic t_disable_suppress;
    wr(3'd0, 8'h1F);
    fetch(1'b0, 12'h000, 6'd2, 1'b1);
    check("R12 enable clear no override", 32'(out_override), 0);
    wr(3'd0, 8'h9F);
    wr(3'd6, 8'h02);
    fetch(1'b0, 12'h000, 6'd2, 1'b1);
    check("R5 suppressed by mode bit 1", 32'(out_override), 0);
    wr(3'd6, 8'hFD);
    fetch(1'b0, 12'h000, 6'd2, 1'b1);
    check("R5 other mode bits no effect", 32'(out_override), 1);
  endtask

  task automatic t_pattern;
    fetch(1'b1, 12'h5AB, 6'd2, 1'b1);
    check("R9 disarmed before bank write", 32'(out_override), 0);
    wr(3'd2, bank_m);
    fetch(1'b1, 12'h5AB, 6'd2, 1'b1);
    check("R9 armed by bank write", 32'(out_override), 1);
    check("R8 pattern address", 32'(out_pat_addr), 32'(exp_pat(bank_m, 12'h5AB, vs_m)));
    fetch(1'b1, 12'h5AB, 6'd2, 1'b0);
    check("R8 sprite phase no override", 32'(out_override), 0);
    wr(3'd7, 8'hFF);
    fetch(1'b1, 12'h5AB, 6'd2, 1'b1);
    check("R9 select 7 keeps armed", 32'(out_override), 1);
    for (int s = 3; s <= 5; s++) begin
      wr(3'(s), 8'h00);
      fetch(1'b1, 12'h5AB, 6'd2, 1'b1);
      check($sformatf("R9 select %0d disarms", s), 32'(out_override), 0);
      wr(3'd2, bank_m);
    end
  endtask

  task automatic t_line_hold;
    hb(8'h40);
    @(negedge clk); scanline = 8'h99;
    fetch(1'b0, 12'h000, 6'd7, 1'b1);
    check("R10 line held between hblanks", 32'(out_ram_addr), 32'(exp_nt(vs_m + 8'h40, 6'd7)));
    hb(8'hF0);
    fetch(1'b0, 12'h000, 6'd7, 1'b1);
    check("R10 new line, row wraps", 32'(out_ram_addr), 32'(exp_nt(vs_m + 8'hF0, 6'd7)));
  endtask

  task automatic t_stall;
    logic [9:0] held;
    @(negedge clk); out_ready = 1'b0;
    fetch(1'b0, 12'h000, 6'd9, 1'b1);
    check("R11 beat valid under stall", 32'(out_valid), 1);
    check("R11 ready low under stall", 32'(req_ready), 0);
    held = out_ram_addr;
    req_valid = 1'b1; tile_idx = 6'd1;
    @(negedge clk);
    check("R11 payload held under stall", 32'(out_ram_addr), 32'(held));
    req_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R11 beat drained", 32'(out_valid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_left();
    t_right();
    t_attr();
    t_disable_suppress();
    t_pattern();
    t_line_hold();
    t_stall();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule